// File: doc/BRIEF.md
# Shared Signalling Channel Contention Arbiter

This block sits inside one terminal on a passive bus that up to eight terminals share. All terminals drive a common signalling bit (the D bit), and the network side echoes the wired-AND result of that bit back to every terminal as the E bit. Before a terminal may start a packet, it must see a run of consecutive echoed ones. The run must reach a terminal count that depends on the terminal's priority. The arbiter counts that run, grants the channel, and asks the HDLC framer to start the opening flag through a request/acknowledge handshake. While the packet is sent, it compares every bit it drives with the echoed bit. On a mismatch it backs off at once and tells the transmit FIFO to drop the rest of the packet.

Priority has two nested parts. A user class input picks a pair of counts: 8/9 for the high class or 10/11 for the low class. An internal level bit picks one member of the pair. The level rises to the higher count after a packet has been sent successfully, and it falls back once a grant has been won at that higher count. As a result, a terminal that has just sent yields to terminals in the same class that are still waiting. The block reports collisions through a sticky interrupt bit, and it reports channel ownership through an acknowledge bit.

The controller is a five-state machine:
- IDLE: no packet is pending, but the run is still counted.
- COUNT: a packet is pending and the run is being counted.
- OPEN: the opening flag has been requested.
- SEND: the terminal owns the channel.
- ABORT: a one-cycle discard after a collision.

Transitions:
- IDLE→COUNT when a request appears.
- COUNT→IDLE when the request is withdrawn.
- COUNT→OPEN on the terminal-count hit.
- OPEN→SEND on the flag acknowledge.
- SEND→ABORT on a collision.
- SEND→COUNT or SEND→IDLE on packet completion, depending on whether another request is pending.
- ABORT→COUNT or ABORT→IDLE in the same way.

Top module: `dchan_arbiter`

## Requirements
- R1: On every bit strobe outside OPEN, SEND and ABORT, an echoed one increments `prio_count` and an echoed zero clears it to 0. The counter is held at 0 while the terminal holds the channel.
- R2: The terminal count is 8 (level low) or 9 (level high) when `low_class`=0, and 10 (level low) or 11 (level high) when `low_class`=1. After reset the level is low.
- R3: A successful packet (`pkt_done` in SEND with no collision in that cycle) sets the level high. A grant won while the level is high sets it low again.
- R4: In COUNT, the bit strobe whose echoed one brings the run to the terminal count is the grant. `flag_req` and `tx_active` rise in the next cycle, and `flag_req` stays high until `flag_ack` is seen.
- R5: `d_out` is 1 in every state except SEND. In SEND it equals `tx_bit`.
- R6: In SEND, a bit strobe with `echo_bit` different from `tx_bit` is a collision. In the next cycle `d_out` is 1, `tx_active` is 0, and `fifo_discard` is high for exactly one cycle.
- R7: `coll_irq` rises in the cycle after a collision. It stays high until an `irq_clr` strobe, and a collision in the same cycle as `irq_clr` keeps it high.
- R8: `chan_ack` rises with the grant. After a collision or a completed packet, it falls at the first `frame_pulse` that follows. Before that pulse it stays high.
- R9: After a collision the run restarts from 0. The machine returns to COUNT when `pkt_req` is high, so a new grant needs a full new run.
- R10: With `pkt_req` low no grant is issued, but the run is still counted and saturates at 15. A request raised after a long run is granted on the next echoed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe per D/E bit period |
| echo_bit | input | 1 | Echoed E bit, valid with `bit_en` |
| tx_bit | input | 1 | Bit the framer wants on the D channel |
| frame_pulse | input | 1 | Line frame boundary strobe |
| pkt_req | input | 1 | A packet is queued for sending |
| low_class | input | 1 | User priority class: 0 high (8/9), 1 low (10/11) |
| flag_ack | input | 1 | Framer has started the opening flag |
| pkt_done | input | 1 | Framer has finished the packet |
| irq_clr | input | 1 | Write-one-to-clear strobe for `coll_irq` |
| d_out | output | 1 | Bit driven onto the D channel |
| flag_req | output | 1 | Request to start the opening flag |
| tx_active | output | 1 | Terminal holds the channel (OPEN or SEND) |
| fifo_discard | output | 1 | Drop the untransmitted rest of the packet |
| coll_irq | output | 1 | Sticky collision interrupt |
| chan_ack | output | 1 | Channel acknowledge status |
| prio_count | output | 4 | Current consecutive-ones run |

## Verification
A wrong run count or level bit appears at the ports as a grant one or more bit periods too early or too late. The scoreboard therefore records the bit index of every `flag_req` rise and every `fifo_discard` pulse, and compares it with the index predicted from the class, the level history and the echo pattern. A machine that gets stuck in SEND or ABORT shows up in the first cycle after the collision bit, as `d_out`, `tx_active` or `fifo_discard` holding the wrong value. Status faults in `coll_irq` and `chan_ack` show up at the next `irq_clr` or `frame_pulse`.

// File: rtl/dca_pkg.sv
package dca_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_OPEN,
        ST_SEND,
        ST_ABORT
    } dca_state_e;

endpackage

// File: rtl/dca_prio_counter.sv
module dca_prio_counter #(
    parameter int CNT_W   = 4,
    parameter int HI_BASE = 8,
    parameter int LO_BASE = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             echo_bit,
    input  logic             hold_clr,
    input  logic             low_class,
    input  logic             grant,
    input  logic             success,
    output logic [CNT_W-1:0] cnt,
    output logic             term_hit
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] HI_T    = CNT_W'(HI_BASE);
    localparam logic [CNT_W-1:0] LO_T    = CNT_W'(LO_BASE);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] term_sel;
    logic             lvl_q;

    always_comb begin
        cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        term_sel = (low_class ? LO_T : HI_T) + {{(CNT_W-1){1'b0}}, lvl_q};
        term_hit = bit_en && echo_bit && !hold_clr && (cnt_inc >= term_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold_clr) begin
            cnt_q <= '0;
        end else if (bit_en) begin
            cnt_q <= echo_bit ? cnt_inc : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else if (success) begin
            lvl_q <= 1'b1;
        end else if (grant && lvl_q) begin
            lvl_q <= 1'b0;
        end
    end

    assign cnt = cnt_q;

    // R1
    zero_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !echo_bit) |=> (cnt == '0));

    // R3
    level_after_success_chk: assert property (@(posedge clk) disable iff (!rst_n)
        success |=> lvl_q);

endmodule

// File: rtl/dca_status.sv
module dca_status (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    input  logic coll,
    input  logic success,
    input  logic frame_pulse,
    input  logic irq_clr,
    output logic coll_irq,
    output logic chan_ack
);

    logic irq_q;
    logic ack_q;
    logic drop_pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (coll) begin
            irq_q <= 1'b1;
        end else if (irq_clr) begin
            irq_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q       <= 1'b0;
            drop_pend_q <= 1'b0;
        end else if (grant) begin
            ack_q       <= 1'b1;
            drop_pend_q <= 1'b0;
        end else if (coll || success) begin
            drop_pend_q <= 1'b1;
        end else if (frame_pulse && drop_pend_q) begin
            ack_q       <= 1'b0;
            drop_pend_q <= 1'b0;
        end
    end

    assign coll_irq = irq_q;
    assign chan_ack = ack_q;

    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_irq && !irq_clr) |=> coll_irq);

    // R7
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coll |=> coll_irq);

    // R8
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_ack && !frame_pulse) |=> chan_ack);

endmodule

// File: rtl/dchan_arbiter.sv
module dchan_arbiter #(
    parameter int CNT_W   = 4,
    parameter int HI_BASE = 8,
    parameter int LO_BASE = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             echo_bit,
    input  logic             tx_bit,
    input  logic             frame_pulse,
    input  logic             pkt_req,
    input  logic             low_class,
    input  logic             flag_ack,
    input  logic             pkt_done,
    input  logic             irq_clr,
    output logic             d_out,
    output logic             flag_req,
    output logic             tx_active,
    output logic             fifo_discard,
    output logic             coll_irq,
    output logic             chan_ack,
    output logic [CNT_W-1:0] prio_count
);

    import dca_pkg::*;

    dca_state_e state_q;
    dca_state_e state_d;

    logic term_hit;
    logic hold_clr;
    logic grant;
    logic coll;
    logic success;

    always_comb begin
        hold_clr = (state_q == ST_OPEN) || (state_q == ST_SEND) || (state_q == ST_ABORT);
        grant    = (state_q == ST_COUNT) && pkt_req && term_hit;
        coll     = (state_q == ST_SEND) && bit_en && (echo_bit != tx_bit);
        success  = (state_q == ST_SEND) && pkt_done && !coll;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pkt_req) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (!pkt_req)  state_d = ST_IDLE;
                else if (grant) state_d = ST_OPEN;
            end
            ST_OPEN: begin
                if (flag_ack) state_d = ST_SEND;
            end
            ST_SEND: begin
                if (coll)         state_d = ST_ABORT;
                else if (success) state_d = pkt_req ? ST_COUNT : ST_IDLE;
            end
            ST_ABORT: begin
                state_d = pkt_req ? ST_COUNT : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        d_out        = 1'b1;
        flag_req     = 1'b0;
        tx_active    = 1'b0;
        fifo_discard = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_COUNT: ;
            ST_OPEN: begin
                flag_req  = 1'b1;
                tx_active = 1'b1;
            end
            ST_SEND: begin
                d_out     = tx_bit;
                tx_active = 1'b1;
            end
            ST_ABORT: begin
                fifo_discard = 1'b1;
            end
            default: ;
        endcase
    end

    dca_prio_counter #(
        .CNT_W   (CNT_W),
        .HI_BASE (HI_BASE),
        .LO_BASE (LO_BASE)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .echo_bit  (echo_bit),
        .hold_clr  (hold_clr),
        .low_class (low_class),
        .grant     (grant),
        .success   (success),
        .cnt       (prio_count),
        .term_hit  (term_hit)
    );

    dca_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant       (grant),
        .coll        (coll),
        .success     (success),
        .frame_pulse (frame_pulse),
        .irq_clr     (irq_clr),
        .coll_irq    (coll_irq),
        .chan_ack    (chan_ack)
    );

    // R4
    grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_req) |-> $past(bit_en && echo_bit && pkt_req));

    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_req && !flag_ack) |=> flag_req);

    // R6
    collision_backoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND && bit_en && (echo_bit != tx_bit)) |=> (fifo_discard && d_out && !tx_active));

    // R9
    restart_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_discard |=> (prio_count == '0 && !fifo_discard));

    // R5
    idle_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active || flag_req) |-> d_out);

endmodule

// File: tb/test_dchan_arbiter.sv
module test_dchan_arbiter;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       echo_bit = 1'b1;
    logic       tx_bit = 1'b1;
    logic       frame_pulse = 1'b0;
    logic       pkt_req = 1'b0;
    logic       low_class = 1'b0;
    logic       flag_ack = 1'b0;
    logic       pkt_done = 1'b0;
    logic       irq_clr = 1'b0;
    logic       d_out;
    logic       flag_req;
    logic       tx_active;
    logic       fifo_discard;
    logic       coll_irq;
    logic       chan_ack;
    logic [3:0] prio_count;

    int checks = 0;
    int errors = 0;
    int bit_no = 0;
    int exp_q[$];
    logic fr_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dchan_arbiter i_dchan_arbiter (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .echo_bit     (echo_bit),
        .tx_bit       (tx_bit),
        .frame_pulse  (frame_pulse),
        .pkt_req      (pkt_req),
        .low_class    (low_class),
        .flag_ack     (flag_ack),
        .pkt_done     (pkt_done),
        .irq_clr      (irq_clr),
        .d_out        (d_out),
        .flag_req     (flag_req),
        .tx_active    (tx_active),
        .fifo_discard (fifo_discard),
        .coll_irq     (coll_irq),
        .chan_ack     (chan_ack),
        .prio_count   (prio_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // event code: kind*100000 + bit index; kind 1 = grant, 2 = discard
    task automatic push_exp(input int kind, input int offs);
        exp_q.push_back(kind * 100000 + bit_no + offs);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (flag_req && !fr_prev) begin
                if (exp_q.size() == 0) chk("R4 unexpected grant", 100000 + bit_no, 0);
                else chk("R2/R4 grant bit", 100000 + bit_no, exp_q.pop_front());
            end
            if (fifo_discard) begin
                if (exp_q.size() == 0) chk("R6 unexpected discard", 200000 + bit_no, 0);
                else chk("R6 discard bit", 200000 + bit_no, exp_q.pop_front());
            end
        end
        fr_prev = flag_req;
    end

    task automatic pair_bit(input logic t, input logic e);
        @(negedge clk);
        bit_no++;
        tx_bit   = t;
        echo_bit = e;
        bit_en   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bit_en   = 1'b0;
    endtask

    task automatic ones(input int n);
        for (int i = 0; i < n; i++) pair_bit(1'b1, 1'b1);
    endtask

    task automatic pulse_ack();
        @(negedge clk); flag_ack = 1'b1;
        @(negedge clk); flag_ack = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); pkt_done = 1'b1;
        @(negedge clk); pkt_done = 1'b0;
    endtask

    task automatic pulse_frame();
        @(negedge clk); frame_pulse = 1'b1;
        @(negedge clk); frame_pulse = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic send_clean_packet();
        pulse_ack();
        chk("R4 flag_req drops after ack", int'(flag_req), 0);
        pair_bit(1'b0, 1'b0);
        tx_bit = 1'b0;
        #1 chk("R5 d_out follows tx_bit", int'(d_out), 0);
        pair_bit(1'b1, 1'b1);
        pair_bit(1'b0, 1'b0);
        tx_bit = 1'b1;
        pulse_done();
        chk("R3 packet completes", int'(tx_active), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk("watchdog expired", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R5 reset d_out", int'(d_out), 1);
        chk("R4 reset flag_req", int'(flag_req), 0);
        chk("R7 reset coll_irq", int'(coll_irq), 0);
        chk("R8 reset chan_ack", int'(chan_ack), 0);
        chk("R1 reset count", int'(prio_count), 0);
        rst_n = 1'b1;

        // R1: run counting and zero clear
        pkt_req = 1'b1;
        ones(3);
        chk("R1 count after three ones", int'(prio_count), 3);
        pair_bit(1'b1, 1'b0);
        chk("R1 zero clears count", int'(prio_count), 0);

        // R2: high class, low level -> 8
        push_exp(1, 8);
        ones(7);
        chk("R2 no grant at 7", int'(flag_req), 0);
        ones(1);
        chk("R4 flag_req after grant", int'(flag_req), 1);
        chk("R8 chan_ack at grant", int'(chan_ack), 1);
        chk("R5 d_out idle in OPEN", int'(d_out), 1);
        repeat (3) @(negedge clk);
        chk("R4 flag_req held", int'(flag_req), 1);
        send_clean_packet();
        chk("R8 chan_ack before frame", int'(chan_ack), 1);
        pulse_frame();
        chk("R8 chan_ack cleared at frame", int'(chan_ack), 0);

        // R3: level high -> 9
        push_exp(1, 9);
        ones(8);
        chk("R3 no grant at 8 with level high", int'(flag_req), 0);
        ones(1);
        pulse_ack();

        // R6: collision
        push_exp(2, 1);
        pair_bit(1'b1, 1'b0);
        chk("R6 d_out released", int'(d_out), 1);
        chk("R6 tx_active low", int'(tx_active), 0);
        chk("R7 coll_irq set", int'(coll_irq), 1);
        @(negedge clk);
        chk("R6 discard one cycle", int'(fifo_discard), 0);
        chk("R9 run restarted", int'(prio_count), 0);
        chk("R8 chan_ack held before frame", int'(chan_ack), 1);
        pulse_frame();
        chk("R8 chan_ack cleared after collision", int'(chan_ack), 0);

        // R9 + R3 revert: level back low -> 8
        push_exp(1, 8);
        ones(8);
        chk("R7 coll_irq sticky", int'(coll_irq), 1);
        pulse_clr();
        chk("R7 coll_irq cleared", int'(coll_irq), 0);
        send_clean_packet();
        pulse_frame();

        // level high again -> 9; finish then low class
        push_exp(1, 9);
        ones(9);
        send_clean_packet();
        pulse_frame();
        // level went high on success, then low class with high level -> 11
        low_class = 1'b1;
        push_exp(1, 11);
        ones(10);
        chk("R2 no grant at 10 low class level high", int'(flag_req), 0);
        ones(1);
        send_clean_packet();
        pulse_frame();
        // level: grant at high reverted, success set high again -> 11
        push_exp(1, 11);
        ones(11);
        pulse_ack();
        // R7: collision with irq_clr in same cycle keeps it set
        push_exp(2, 1);
        @(negedge clk);
        bit_no++;
        tx_bit = 1'b1; echo_bit = 1'b0; bit_en = 1'b1; irq_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bit_en = 1'b0; irq_clr = 1'b0;
        chk("R7 collision beats clear", int'(coll_irq), 1);
        pulse_clr();
        pulse_frame();
        // after grant at high level, level is low -> 10
        push_exp(1, 10);
        ones(9);
        chk("R2 no grant at 9 low class", int'(flag_req), 0);
        ones(1);
        pkt_req = 1'b0;
        send_clean_packet();
        pulse_frame();

        // R10: no request, saturating run
        ones(12);
        chk("R10 no grant without request", int'(flag_req), 0);
        chk("R10 count tracked", int'(prio_count), 12);
        ones(4);
        chk("R10 count saturates", int'(prio_count), 15);
        @(negedge clk); pkt_req = 1'b1;
        push_exp(1, 1);
        ones(1);
        chk("R10 grant after long run", int'(flag_req), 1);
        pkt_req = 1'b0;
        send_clean_packet();

        repeat (4) @(negedge clk);
        chk("R4/R6 all expected events seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule